// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 serial management transactions from a system-clock domain to an external PHY over a management clock and a bidirectional data line. Software drives it through six 32-bit registers on a simple word bus. One register sets the clock prescale and holds the management reset. One launches reads. One holds the PHY and register address. One takes write data and launches writes. One shows the busy flag, and one returns read data.

The management clock is made from the system clock by two dividers in series. The first is chosen by a 3-bit code and can be 4, 6, 8, 10, 14, 20 or 28. The second divides by a fixed 8. The clock idles low and runs only while a frame is active. The master changes its data output after each falling management-clock edge. It samples the PHY on each rising edge, and it releases its output driver for the turnaround and data bits of a read.

Top module: `mdio_master_top`

## Requirements
- R1: Register byte offsets and field positions are fixed as follows.
  - Configuration at 0x00: clock code in bits 2:0, management reset in bit 31.
  - Command at 0x04: read request in bit 0.
  - Address at 0x08: PHY address in bits 12:8, register address in bits 4:0.
  - Write data at 0x0C: bits 15:0.
  - Indicator at 0x10: busy in bit 0.
  - Read data at 0x14: bits 15:0.
  - After reset, busy reads 0, the management clock is low and the output enable is 0. Reads return the stored fields at these positions.
- R2: Writing the write-data register launches a 64-bit frame. It carries 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10 and the 16 data bits, all MSB first.
- R3: A 0-to-1 change of command bit 0 launches a read frame with opcode 10. Writing 1 while the bit is already 1 launches nothing.
- R4: In a read frame the output enable is 0 for bit slots 46 to 63 (turnaround and data) and 1 before them. When busy clears, the 16 bits sampled on the last 16 rising edges are readable at 0x14. With no PHY driving the pulled-up line, that value is 0xFFFF.
- R5: Clock codes 1 to 7 give prescale ratios 4, 6, 8, 10, 14, 20 and 28, and code 0 acts as code 1. The management-clock period is the ratio times 8 system clocks.
- R6: The management clock is low whenever the block is idle. Each frame produces exactly 64 rising edges, and the clock is low again when busy clears.
- R7: Busy is 1 from the cycle after the launching write until the frame ends. That is exactly 64 × ratio × 8 system-clock cycles.
- R8: Setting the management reset bit aborts any frame on the next cycle: busy goes to 0, the clock goes low and the output enable goes to 0. While the bit is set, no frame launches. Clearing it restores normal operation.
- R9: A write-data write or a read request that arrives while busy is 1 is ignored. The running frame's contents and length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, 0 when not selected |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Serial data seen on the shared line |

## Verification
Frames are tried in both directions at every clock code, including code 0. The address fields use alternating and extreme bit patterns so that a swapped, shifted or truncated field shows up in the decoded frame. Write data and PHY replies with a single high bit, a single low bit and mixed patterns tell MSB-first order apart from LSB-first order and expose an off-by-one capture. Measuring the busy length and the clock period for each code tells every ratio apart from its neighbours. Directed runs cover an absent PHY, a repeated read request, launches attempted mid-frame, and a management reset issued mid-frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int VAL_W  = 16;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W  = $clog2(FRAME_BITS);

    localparam logic [ADDR_W-1:0] OFF_CFG = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CMD = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_ADR = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_WDT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_IND = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_RDT = 5'h14;

    localparam int CFG_RST_BIT = 31;
    localparam int ADR_PHY_LSB = 8;

    localparam logic [IDX_W-1:0] TA_SLOT   = IDX_W'(46);
    localparam logic [IDX_W-1:0] DATA_SLOT = IDX_W'(48);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(FRAME_BITS - 1);

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic             is_read;
        logic [2:0]       clk_code;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regad;
        logic [VAL_W-1:0] wdata;
    } mdio_req_t;

    function automatic int unsigned prescale_of(input logic [2:0] code);
        case (code)
            3'd2:    return 6;
            3'd3:    return 8;
            3'd4:    return 10;
            3'd5:    return 14;
            3'd6:    return 20;
            3'd7:    return 28;
            default: return 4;
        endcase
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
        mdio_op_e op;
        logic [1:0] ta;
        logic [VAL_W-1:0] body;
        op   = r.is_read ? OP_READ : OP_WRITE;
        ta   = r.is_read ? 2'b11 : 2'b10;
        body = r.is_read ? {VAL_W{1'b1}} : r.wdata;
        return {{32{1'b1}}, 2'b01, op, r.phy, r.regad, ta, body};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
    import mdio_pkg::*;
#(
    parameter int FIX_DIV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [2:0] code,
    output logic       tick
);
    localparam int MAX_HALF = 28 * FIX_DIV / 2;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = CNT_W'(prescale_of(code) * FIX_DIV / 2 - 1);
        tick    = en && (cnt == half_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt <= half_m1));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  mdio_req_t        req,
    input  logic             tick,
    input  logic             mdio_i,
    output logic             busy,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             done_rd,
    output logic [2:0]       code_q,
    output logic [VAL_W-1:0] rd_data
);
    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      idx;
    logic                  is_rd;
    logic                  rise, fall;

    always_comb begin
        rise    = busy && tick && !mdc;
        fall    = busy && tick && mdc;
        mdio_o  = shreg[FRAME_BITS-1];
        mdio_oe = busy && !(is_rd && idx >= TA_SLOT);
        done_rd = fall && is_rd && (idx == LAST_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            mdc     <= 1'b0;
            shreg   <= '1;
            idx     <= '0;
            is_rd   <= 1'b0;
            code_q  <= 3'd0;
            rd_data <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            mdc    <= 1'b0;
            shreg  <= build_frame(req);
            idx    <= '0;
            is_rd  <= req.is_read;
            code_q <= req.clk_code;
        end else if (rise) begin
            mdc <= 1'b1;
            if (is_rd && idx >= DATA_SLOT) rd_data <= {rd_data[VAL_W-2:0], mdio_i};
        end else if (fall) begin
            mdc <= 1'b0;
            if (idx == LAST_SLOT) begin
                busy  <= 1'b0;
                shreg <= '1;
            end else begin
                idx   <= idx + 1'b1;
                shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
            end
        end
    end

    // R6
    mdc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R6
    mdc_move_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mdc));

    // R6
    mdio_change_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fall) |=> $stable(mdio_o));

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done_rd,
    input  logic [VAL_W-1:0]  rd_data,
    output logic              mgmt_rst,
    output logic              start,
    output mdio_req_t         req
);
    logic [2:0]       cfg_code;
    logic             cmd_rd;
    logic [PHY_W-1:0] adr_phy;
    logic [REG_W-1:0] adr_reg;
    logic [VAL_W-1:0] wdt_q;
    logic [VAL_W-1:0] rdt_q;
    logic             wr, wr_cfg, wr_cmd, wr_adr, wr_wdt;
    logic             go_wr, go_rd;
    logic             unused_bits;

    assign unused_bits = ^bus_wdata[30:16];

    always_comb begin
        wr     = bus_sel && bus_wr;
        wr_cfg = wr && (bus_addr == OFF_CFG);
        wr_cmd = wr && (bus_addr == OFF_CMD);
        wr_adr = wr && (bus_addr == OFF_ADR);
        wr_wdt = wr && (bus_addr == OFF_WDT);
        go_wr  = wr_wdt;
        go_rd  = wr_cmd && bus_wdata[0] && !cmd_rd;
        start  = (go_wr || go_rd) && !busy && !mgmt_rst;
        req.is_read  = go_rd;
        req.clk_code = cfg_code;
        req.phy      = adr_phy;
        req.regad    = adr_reg;
        req.wdata    = bus_wdata[VAL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_code <= 3'd0;
            mgmt_rst <= 1'b0;
            cmd_rd   <= 1'b0;
            adr_phy  <= '0;
            adr_reg  <= '0;
            wdt_q    <= '0;
            rdt_q    <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_code <= bus_wdata[2:0];
                mgmt_rst <= bus_wdata[CFG_RST_BIT];
            end
            if (wr_cmd) cmd_rd <= bus_wdata[0];
            if (wr_adr) begin
                adr_phy <= bus_wdata[ADR_PHY_LSB +: PHY_W];
                adr_reg <= bus_wdata[REG_W-1:0];
            end
            if (wr_wdt)  wdt_q <= bus_wdata[VAL_W-1:0];
            if (done_rd) rdt_q <= rd_data;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFF_CFG: bus_rdata = {mgmt_rst, 28'd0, cfg_code};
                OFF_CMD: bus_rdata = {31'd0, cmd_rd};
                OFF_ADR: bus_rdata = {19'd0, adr_phy, 3'd0, adr_reg};
                OFF_WDT: bus_rdata = {16'd0, wdt_q};
                OFF_IND: bus_rdata = {31'd0, busy};
                OFF_RDT: bus_rdata = {16'd0, rdt_q};
                default: bus_rdata = '0;
            endcase
        end
    end

    // R4
    rdt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_rd |=> $stable(rdt_q));

    // R9
    no_launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

endmodule

// File: rtl/mdio_master_top.sv
module mdio_master_top
    import mdio_pkg::*;
#(
    parameter int FIX_DIV = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             mgmt_rst, eng_rst;
    logic             start, busy, done_rd, tick;
    logic [2:0]       code_q;
    logic [VAL_W-1:0] rd_data;
    mdio_req_t        req;

    assign eng_rst = rst || mgmt_rst;

    mdio_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done_rd   (done_rd),
        .rd_data   (rd_data),
        .mgmt_rst  (mgmt_rst),
        .start     (start),
        .req       (req)
    );

    mdio_clkdiv #(.FIX_DIV(FIX_DIV)) u_div (
        .clk  (clk),
        .rst  (eng_rst),
        .en   (busy),
        .code (code_q),
        .tick (tick)
    );

    mdio_frame_engine u_eng (
        .clk     (clk),
        .rst     (eng_rst),
        .start   (start),
        .req     (req),
        .tick    (tick),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done_rd (done_rd),
        .code_q  (code_q),
        .rd_data (rd_data)
    );

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        mgmt_rst |=> (!busy && !mdc && !mdio_oe));

    // R7
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !mgmt_rst) |=> busy);

endmodule

// File: tb/mdio_master_top_tb_top.sv
module mdio_master_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_CFG = 5'h00, A_CMD = 5'h04, A_ADR = 5'h08,
                           A_WDT = 5'h0C, A_IND = 5'h10, A_RDT = 5'h14;

    // {is_read, code[2:0], phy[4:0], reg[4:0], data/reply[15:0]}
    localparam int NVEC = 8;
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0, 3'd1, 5'h01, 5'h00, 16'h1234},
        {1'b1, 3'd2, 5'h1F, 5'h1F, 16'hA5C3},
        {1'b0, 3'd3, 5'h15, 5'h0A, 16'h8001},
        {1'b1, 3'd4, 5'h0A, 5'h15, 16'h0000},
        {1'b0, 3'd5, 5'h10, 5'h01, 16'h5A5A},
        {1'b1, 3'd6, 5'h03, 5'h1C, 16'h7FFE},
        {1'b0, 3'd7, 5'h1E, 5'h11, 16'h0F0F},
        {1'b1, 3'd0, 5'h00, 5'h02, 16'h8000}
    };

    logic clk = 0, rst = 1;
    logic bus_sel = 0, bus_wr = 0;
    logic [4:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic mdc, mdio_o, mdio_oe, mdio_i, line;
    logic phy_drive = 1'b1;

    int checks = 0, errors = 0, cyc = 0;
    int rc = 0, t0 = 0, t1 = 0;
    logic phy_en = 0, rd_mode = 0, oe_bad = 0;
    logic [15:0] phy_resp = 0;
    logic [63:0] cap64 = 0;

    assign line   = mdio_oe ? mdio_o : phy_drive;
    assign mdio_i = line;

    mdio_master_top dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge mdc) begin
        cap64 = {cap64[62:0], line};
        if (rd_mode && rc >= 46 && mdio_oe) oe_bad = 1;
        if ((!rd_mode || rc < 46) && !mdio_oe) oe_bad = 1;
        if (rc == 0) t0 = cyc;
        if (rc == 1) t1 = cyc;
        rc++;
    end

    always @(negedge mdc) begin
        if (phy_en && rd_mode && rc >= 48 && rc <= 63) phy_drive = phy_resp[63 - rc];
        else phy_drive = 1'b1;
    end

    function automatic int ratio_of(input logic [2:0] c);
        case (c)
            3'd2: return 6;   3'd3: return 8;   3'd4: return 10;
            3'd5: return 14;  3'd6: return 20;  3'd7: return 28;
            default: return 4;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_addr = A_IND;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(output int t_end);
        int guard;
        guard = 0;
        bus_sel = 1; bus_wr = 0; bus_addr = A_IND;
        #1;
        while (bus_rdata[0] && guard < 40000) begin
            @(negedge clk); #1; guard++;
        end
        t_end = cyc;
    endtask

    task automatic phy_arm(input logic rd, input logic en, input logic [15:0] resp);
        rc = 0; oe_bad = 0; cap64 = 0; phy_drive = 1;
        rd_mode = rd; phy_en = en; phy_resp = resp;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rv;
        int tl, te, r;
        logic [63:0] exp;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        bus_read(A_IND, rv);
        check("R1 busy after reset", rv, 0);
        check("R1 mdc after reset", mdc, 0);
        check("R1 oe after reset", mdio_oe, 0);
        bus_write(A_ADR, 32'h0000_1F05);
        bus_read(A_ADR, rv);
        check("R1 address fields", rv, 32'h0000_1F05);
        bus_write(A_CFG, 32'h0000_0006);
        bus_read(A_CFG, rv);
        check("R1 config field", rv, 32'h0000_0006);

        // Table of frames: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            logic isr; logic [2:0] c; logic [4:0] p, g; logic [15:0] d;
            {isr, c, p, g, d} = VEC[i];
            r = ratio_of(c);
            bus_write(A_CFG, {29'd0, c});
            bus_write(A_ADR, {19'd0, p, 3'd0, g});
            phy_arm(isr, 1, d);
            if (isr) bus_write(A_CMD, 32'd1);
            else     bus_write(A_WDT, {16'd0, d});
            tl = cyc;
            wait_idle(te);
            check("R7 busy length", te - tl, 64 * r * 8);
            check("R5 mdc period", t1 - t0, r * 8);
            check("R6 rising edge count", rc, 64);
            check("R6 mdc low at end", mdc, 0);
            exp = {32'hFFFF_FFFF, 2'b01, (isr ? 2'b10 : 2'b01), p, g, 18'd0};
            if (isr) begin
                check("R3 read frame header", {cap64[63:18], 18'd0}, exp);
                check("R4 oe release", oe_bad, 0);
                bus_read(A_RDT, rv);
                check("R4 read data", rv, {16'd0, d});
                bus_write(A_CMD, 32'd0);
            end else begin
                check("R2 write frame", cap64, {exp[63:18], 2'b10, d});
                check("R2 oe held", oe_bad, 0);
            end
        end

        // R4 absent PHY
        bus_write(A_CFG, 32'd1);
        phy_arm(1, 0, 16'h0);
        bus_write(A_CMD, 32'd1);
        wait_idle(te);
        bus_read(A_RDT, rv);
        check("R4 no PHY reply", rv, 32'h0000_FFFF);

        // R3 repeated 1 launches nothing
        bus_write(A_CMD, 32'd1);
        repeat (5) @(negedge clk);
        bus_read(A_IND, rv);
        check("R3 no relaunch on 1->1", rv, 0);
        bus_write(A_CMD, 32'd0);
        bus_write(A_CMD, 32'd1);
        bus_read(A_IND, rv);
        check("R3 relaunch on 0->1", rv, 1);
        wait_idle(te);
        bus_write(A_CMD, 32'd0);

        // R9 launches while busy are ignored
        bus_write(A_ADR, {19'd0, 5'h0C, 3'd0, 5'h03});
        phy_arm(0, 1, 16'h0);
        bus_write(A_WDT, 32'h0000_1357);
        tl = cyc;
        repeat (400) @(negedge clk);
        bus_write(A_WDT, 32'h0000_BEEF);
        bus_write(A_CMD, 32'd1);
        wait_idle(te);
        check("R9 frame length kept", te - tl, 2048);
        check("R9 frame data kept", cap64,
              {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0C, 5'h03, 2'b10, 16'h1357});
        bus_write(A_CMD, 32'd0);

        // R8 abort by management reset
        phy_arm(1, 1, 16'h4321);
        bus_write(A_CMD, 32'd1);
        repeat (300) @(negedge clk);
        bus_write(A_CFG, 32'h8000_0001);
        bus_read(A_IND, rv);
        check("R8 busy cleared", rv, 0);
        check("R8 mdc low", mdc, 0);
        check("R8 oe released", mdio_oe, 0);
        bus_write(A_CMD, 32'd0);
        bus_write(A_WDT, 32'h0000_AAAA);
        repeat (3) @(negedge clk);
        bus_read(A_IND, rv);
        check("R8 no launch in reset", rv, 0);
        bus_write(A_CFG, 32'h0000_0001);
        phy_arm(0, 1, 16'h0);
        bus_write(A_WDT, 32'h0000_C3C3);
        tl = cyc;
        wait_idle(te);
        check("R8 normal after release", te - tl, 2048);
        check("R8 frame after release", cap64[17:0], {2'b10, 16'hC3C3});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule